// File: doc/BRIEF.md
# Oscillation Stabilization Wait Timer

This block measures how long the high-speed oscillator has been running since it last started. It counts cycles of that oscillator after reset release, after a start event, after a stop-mode release, or after the enable comes back. It reports progress against five power-of-two thresholds: 2^11, 2^13, 2^14, 2^15 and 2^16 cycles. A status word has one sticky flag per threshold. Software polls it before it moves the CPU clock onto the high-speed source.

A stable output rises when the count reaches the threshold named by the currently applied select value. The applied select is taken from the select input only on a stop-release event. Reset and plain start events keep the value already applied, and reset makes that value the longest wait. A configuration input marks the source as an RC oscillator. In that case no wait is needed, and the status word and stable output read as fully set whenever the oscillator is enabled.

Top module: `osc_settle_timer`

## Requirements
- R1: While reset is held and after it is sampled, with the RC input low, the status word is 0 and the stable output is low.
- R2: After a restart, status bit 0 sets after exactly 2^11 counted cycles, and bits 1, 2, 3 and 4 set after exactly 2^13, 2^14, 2^15 and 2^16 counted cycles. The restart is the last edge at which reset, a start, a stop release or a low enable was sampled.
- R3: Status bits are sticky. They always form a run of ones from bit 0 upward. The count saturates at 2^16, so every flag stays set for as long as the oscillator keeps running.
- R4: Select encodings 0, 1, 2, 3 and 4 choose 2^11, 2^13, 2^14, 2^15 and 2^16 cycles, and encodings 5 to 7 choose 2^16. The stable output rises at the same edge as the status bit of the chosen threshold, and never before status bit 0.
- R5: A stop-release pulse restarts the count and applies the select input sampled with it.
- R6: A start pulse restarts the count and ignores the select input, keeping the applied select. After reset the applied select is the 2^16 wait.
- R7: An enable input sampled low clears the count, the status word and the stable output. Counting resumes from zero once the enable is high again.
- R8: With the RC input high and the enable high, the status word reads 5'b11111 and the stable output reads high in the same cycle. With the enable low, the RC input has no effect.
- R9: A restart during a count clears the status word and the stable output at the restart edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_osc | input | 1 | High-speed oscillator clock |
| rst_n | input | 1 | Synchronous active-low reset |
| osc_en_i | input | 1 | Oscillator running; low clears the count |
| osc_start_i | input | 1 | Oscillator start pulse; restarts the count |
| stop_rel_i | input | 1 | Stop-release pulse; restarts the count and applies the select |
| wait_sel_i | input | 3 | Wait-length select, encodings per R4 |
| rc_src_i | input | 1 | Source is an RC oscillator; no wait needed |
| stat_o | output | 5 | Sticky threshold flags, bit 0 = 2^11 up to bit 4 = 2^16 |
| stable_o | output | 1 | Selected threshold reached |

## Verification
A counter that is off by one shows up as a status bit set one cycle early or late at a threshold boundary. The bench therefore samples both sides of every boundary. A wrong applied select, for example one loaded on a start pulse or a bad clamp of unused encodings, only becomes visible when the stable output rises at the wrong boundary. That can be as much as 2^16 cycles after the restart, so the full longest waits are run. A flag that is not cleared on a restart or a disable shows within one cycle of that event.

// File: rtl/ost_pkg.sv
// Package: shared constants and helpers for the oscillation wait timer.
// Assumes five thresholds, held in ascending order of exponent.
package ost_pkg;
    localparam int NUM_THR = 5;
    localparam int MAX_EXP = 16;
    localparam int CNT_W   = MAX_EXP + 1;
    localparam int SEL_W   = 3;

    // Exponent of the threshold behind status bit idx.
    function automatic int unsigned thr_exp(input int idx);
        case (idx)
            0:       return 11;
            1:       return 13;
            2:       return 14;
            3:       return 15;
            default: return 16;
        endcase
    endfunction
endpackage

// File: rtl/ost_counter.sv
// Module: saturating up-counter of oscillator cycles.
// Assumes clr_i takes priority over counting; it stops at SAT_VAL.
module ost_counter #(
    parameter int CNT_W   = 17,
    parameter int SAT_EXP = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             run_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic [CNT_W-1:0] cnt_nxt_o
);
    localparam logic [CNT_W-1:0] SAT_VAL = {{(CNT_W-1){1'b0}}, 1'b1} << SAT_EXP;

    logic [CNT_W-1:0] cnt_q;

    // Next count: clear, hold at saturation, or step by one.
    always_comb begin
        if (clr_i)
            cnt_nxt_o = '0;
        else if (run_i && (cnt_q < SAT_VAL))
            cnt_nxt_o = cnt_q + 1'b1;
        else
            cnt_nxt_o = cnt_q;
    end

    // Count register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else
            cnt_q <= cnt_nxt_o;
    end

    assign cnt_o = cnt_q;
endmodule

// File: rtl/ost_flags.sv
// Module: one sticky flag per power-of-two threshold.
// Assumes cnt_nxt_i is the next count, so each flag sets at the edge where
// the count reaches its threshold.
module ost_flags #(
    parameter int CNT_W   = 17,
    parameter int NUM_THR = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr_i,
    input  logic [CNT_W-1:0]   cnt_nxt_i,
    output logic [NUM_THR-1:0] flag_o
);
    import ost_pkg::*;

    for (genvar gi = 0; gi < NUM_THR; gi++) begin : g_flag
        localparam logic [CNT_W-1:0] THR = {{(CNT_W-1){1'b0}}, 1'b1} << thr_exp(gi);
        logic flag_q;

        // Set once the count reaches THR; cleared only by a restart.
        always_ff @(posedge clk) begin
            if (!rst_n)
                flag_q <= 1'b0;
            else if (clr_i)
                flag_q <= 1'b0;
            else if (cnt_nxt_i >= THR)
                flag_q <= 1'b1;
        end

        assign flag_o[gi] = flag_q;
    end
endmodule

// File: rtl/ost_sel.sv
// Module: holds the applied wait select as a threshold index.
// Assumes encodings at or above NUM_THR map to the longest threshold.
module ost_sel #(
    parameter int SEL_W   = 3,
    parameter int NUM_THR = 5,
    parameter int IDX_W   = $clog2(NUM_THR)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [SEL_W-1:0] sel_i,
    output logic [IDX_W-1:0] idx_o
);
    localparam logic [IDX_W-1:0] LONGEST = IDX_W'(NUM_THR - 1);

    logic [IDX_W-1:0] dec_idx;
    logic [IDX_W-1:0] idx_q;

    // Clamp unused encodings to the longest wait.
    always_comb begin
        if (int'(sel_i) < NUM_THR)
            dec_idx = IDX_W'(sel_i);
        else
            dec_idx = LONGEST;
    end

    // Applied-select register; reset gives the longest wait.
    always_ff @(posedge clk) begin
        if (!rst_n)
            idx_q <= LONGEST;
        else if (load_i)
            idx_q <= dec_idx;
    end

    assign idx_o = idx_q;
endmodule

// File: rtl/osc_settle_timer.sv
// Module: oscillation stabilization wait timer (top).
// Counts oscillator cycles after every restart, flags each threshold in a
// status word and raises stable at the applied threshold. An RC source
// bypasses the wait. Assumes all inputs are synchronous to clk_osc.
module osc_settle_timer #(
    parameter int NUM_THR = ost_pkg::NUM_THR,
    parameter int CNT_W   = ost_pkg::CNT_W,
    parameter int SEL_W   = ost_pkg::SEL_W,
    parameter int MAX_EXP = ost_pkg::MAX_EXP
) (
    input  logic               clk_osc,
    input  logic               rst_n,
    input  logic               osc_en_i,
    input  logic               osc_start_i,
    input  logic               stop_rel_i,
    input  logic [SEL_W-1:0]   wait_sel_i,
    input  logic               rc_src_i,
    output logic [NUM_THR-1:0] stat_o,
    output logic               stable_o
);
    localparam int IDX_W = $clog2(NUM_THR);

    logic               restart;
    logic [CNT_W-1:0]   cnt_q;
    logic [CNT_W-1:0]   cnt_nxt;
    logic [NUM_THR-1:0] flag_q;
    logic [IDX_W-1:0]   sel_idx;
    logic               rc_bypass;

    // Any event that makes the oscillator start over.
    assign restart   = osc_start_i | stop_rel_i | ~osc_en_i;
    assign rc_bypass = rc_src_i & osc_en_i;

    ost_counter #(
        .CNT_W   (CNT_W),
        .SAT_EXP (MAX_EXP)
    ) u_cnt (
        .clk       (clk_osc),
        .rst_n     (rst_n),
        .clr_i     (restart),
        .run_i     (osc_en_i),
        .cnt_o     (cnt_q),
        .cnt_nxt_o (cnt_nxt)
    );

    ost_flags #(
        .CNT_W   (CNT_W),
        .NUM_THR (NUM_THR)
    ) u_flags (
        .clk       (clk_osc),
        .rst_n     (rst_n),
        .clr_i     (restart),
        .cnt_nxt_i (cnt_nxt),
        .flag_o    (flag_q)
    );

    ost_sel #(
        .SEL_W   (SEL_W),
        .NUM_THR (NUM_THR),
        .IDX_W   (IDX_W)
    ) u_sel (
        .clk    (clk_osc),
        .rst_n  (rst_n),
        .load_i (stop_rel_i),
        .sel_i  (wait_sel_i),
        .idx_o  (sel_idx)
    );

    // Output view: RC bypass forces everything set; otherwise the flags.
    always_comb begin
        if (rc_bypass) begin
            stat_o   = '1;
            stable_o = 1'b1;
        end else begin
            stat_o   = flag_q;
            stable_o = flag_q[sel_idx];
        end
    end
endmodule

// File: rtl/ost_checker.sv
// Module: property checker for osc_settle_timer, attached by bind.
// Assumes it sees the top ports plus the internal count.
module ost_checker #(
    parameter int NUM_THR = 5,
    parameter int CNT_W   = 17,
    parameter int MAX_EXP = 16
) (
    input logic               clk_osc,
    input logic               rst_n,
    input logic               osc_en_i,
    input logic               osc_start_i,
    input logic               stop_rel_i,
    input logic               rc_src_i,
    input logic [NUM_THR-1:0] stat_o,
    input logic               stable_o,
    input logic [CNT_W-1:0]   cnt_q
);
    localparam logic [CNT_W-1:0] SAT_VAL = {{(CNT_W-1){1'b0}}, 1'b1} << MAX_EXP;

    logic restart_ev;
    assign restart_ev = osc_start_i | stop_rel_i | ~osc_en_i;

    // R3: the count never passes the saturation value.
    p_no_overflow_r3: assert property (@(posedge clk_osc) disable iff (!rst_n)
        cnt_q <= SAT_VAL);

    // R3: status bits form a run of ones from bit 0.
    p_thermo_r3: assert property (@(posedge clk_osc) disable iff (!rst_n)
        (stat_o & NUM_THR'(stat_o + 1'b1)) == '0);

    // R3: a set first flag stays set while nothing restarts.
    p_sticky_r3: assert property (@(posedge clk_osc) disable iff (!rst_n)
        (stat_o[0] && !restart_ev && !rc_src_i) |=> stat_o[0]);

    // R4: stable never precedes the shortest threshold.
    p_stable_needs_first_r4: assert property (@(posedge clk_osc) disable iff (!rst_n)
        stable_o |-> stat_o[0]);

    // R9: a restart edge leaves the flags cleared.
    p_clear_r9: assert property (@(posedge clk_osc) disable iff (!rst_n)
        restart_ev |=> (((stat_o == '0) && !stable_o) || (rc_src_i && osc_en_i)));

    // R8: the RC bypass shows all flags set and stable.
    p_rc_all_r8: assert property (@(posedge clk_osc) disable iff (!rst_n)
        (rc_src_i && osc_en_i) |-> ((&stat_o) && stable_o));
endmodule

bind osc_settle_timer ost_checker #(
    .NUM_THR (NUM_THR),
    .CNT_W   (CNT_W),
    .MAX_EXP (MAX_EXP)
) u_ost_checker (
    .clk_osc     (clk_osc),
    .rst_n       (rst_n),
    .osc_en_i    (osc_en_i),
    .osc_start_i (osc_start_i),
    .stop_rel_i  (stop_rel_i),
    .rc_src_i    (rc_src_i),
    .stat_o      (stat_o),
    .stable_o    (stable_o),
    .cnt_q       (cnt_q)
);

// File: tb/test_osc_settle_timer.sv
// Directed bench for osc_settle_timer: one task per scenario.
module test_osc_settle_timer;
    logic       clk_osc = 1'b0;
    logic       rst_n;
    logic       osc_en_i;
    logic       osc_start_i;
    logic       stop_rel_i;
    logic [2:0] wait_sel_i;
    logic       rc_src_i;
    logic [4:0] stat_o;
    logic       stable_o;

    int n_checks = 0;
    int n_errors = 0;

    always #5 clk_osc = ~clk_osc;

    osc_settle_timer i_osc_settle_timer (
        .clk_osc     (clk_osc),
        .rst_n       (rst_n),
        .osc_en_i    (osc_en_i),
        .osc_start_i (osc_start_i),
        .stop_rel_i  (stop_rel_i),
        .wait_sel_i  (wait_sel_i),
        .rc_src_i    (rc_src_i),
        .stat_o      (stat_o),
        .stable_o    (stable_o)
    );

    function automatic int thr(input int i);
        case (i)
            0: return 2048;
            1: return 8192;
            2: return 16384;
            3: return 32768;
            default: return 65536;
        endcase
    endfunction

    task automatic check(input string req, input logic [4:0] e_stat, input logic e_stb);
        n_checks++;
        if (stat_o !== e_stat || stable_o !== e_stb) begin
            n_errors++;
            $display("FAIL %s: stat=%b stable=%b expected stat=%b stable=%b",
                     req, stat_o, stable_o, e_stat, e_stb);
        end
    endtask

    task automatic wait_edges(input int n);
        repeat (n) @(posedge clk_osc);
        @(negedge clk_osc);
    endtask

    task automatic pulse_stop(input logic [2:0] sel);
        wait_sel_i = sel;
        stop_rel_i = 1'b1;
        wait_edges(1);
        stop_rel_i = 1'b0;
    endtask

    task automatic pulse_start(input logic [2:0] sel);
        wait_sel_i  = sel;
        osc_start_i = 1'b1;
        wait_edges(1);
        osc_start_i = 1'b0;
    endtask

    task automatic finish_run;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    endtask

    // R1, R2, R3, R6: reset, then a full run with the reset select (2^16).
    task automatic t_reset_full;
        int prev;
        rst_n = 1'b0; osc_en_i = 1'b1; osc_start_i = 1'b0; stop_rel_i = 1'b0;
        wait_sel_i = 3'd0; rc_src_i = 1'b0;
        wait_edges(3);
        check("R1 in reset", 5'b0, 1'b0);
        rst_n = 1'b1;
        prev = 0;
        for (int i = 0; i < 5; i++) begin
            wait_edges(thr(i) - 1 - prev);
            check("R2 before threshold", 5'((1 << i) - 1), 1'b0);
            wait_edges(1);
            check("R2 at threshold, R6 reset select", 5'((1 << (i + 1)) - 1), i == 4);
            prev = thr(i);
        end
        wait_edges(100);
        check("R3 saturated and sticky", 5'b11111, 1'b1);
    endtask

    // R5, R4: stop release with encoding 0 and then encoding 1.
    task automatic t_stop_sel;
        pulse_stop(3'd0);
        check("R9 cleared by stop release", 5'b0, 1'b0);
        wait_edges(2047);
        check("R5 sel0 before", 5'b0, 1'b0);
        wait_edges(1);
        check("R4 sel0 at 2^11", 5'b00001, 1'b1);
        pulse_stop(3'd1);
        wait_edges(8191);
        check("R4 sel1 before", 5'b00001, 1'b0);
        wait_edges(1);
        check("R4 sel1 at 2^13", 5'b00011, 1'b1);
    endtask

    // R6, R9: a start pulse clears and keeps the applied select.
    task automatic t_start_keeps_sel;
        pulse_start(3'd0);
        check("R9 cleared by start", 5'b0, 1'b0);
        wait_edges(2048);
        check("R6 select ignored on start", 5'b00001, 1'b0);
        wait_edges(8192 - 2048 - 1);
        check("R6 before 2^13", 5'b00001, 1'b0);
        wait_edges(1);
        check("R6 stable at 2^13", 5'b00011, 1'b1);
    endtask

    // R4: an unused encoding gives the longest wait.
    task automatic t_unused_sel;
        pulse_stop(3'd7);
        wait_edges(65535);
        check("R4 sel7 before 2^16", 5'b01111, 1'b0);
        wait_edges(1);
        check("R4 sel7 at 2^16", 5'b11111, 1'b1);
    endtask

    // R7: a low enable clears everything; counting restarts from zero.
    task automatic t_disable;
        pulse_stop(3'd0);
        wait_edges(100);
        osc_en_i = 1'b0;
        wait_edges(1);
        check("R7 disabled", 5'b0, 1'b0);
        wait_edges(4);
        check("R7 still disabled", 5'b0, 1'b0);
        osc_en_i = 1'b1;
        wait_edges(2047);
        check("R7 restart from zero before", 5'b0, 1'b0);
        wait_edges(1);
        check("R7 restart from zero at 2^11", 5'b00001, 1'b1);
    endtask

    // R8: RC source bypass, and no effect while the enable is low.
    task automatic t_rc;
        pulse_stop(3'd4);
        rc_src_i = 1'b1;
        #1;
        check("R8 bypass same cycle", 5'b11111, 1'b1);
        @(negedge clk_osc);
        osc_en_i = 1'b0;
        wait_edges(1);
        check("R8 no effect when disabled", 5'b0, 1'b0);
        rc_src_i = 1'b0;
        osc_en_i = 1'b1;
        wait_edges(1);
        check("R8 bypass off", 5'b0, 1'b0);
    endtask

    initial begin
        t_reset_full();
        t_stop_sel();
        t_start_keeps_sel();
        t_unused_sel();
        t_disable();
        t_rc();
        finish_run();
    end

    initial begin
        repeat (195000) @(posedge clk_osc);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: run did not end, expected completion");
        finish_run();
    end
endmodule